// File: doc/BRIEF.md
# Pass-Through Parallel Port Host Front End with EPP Gating

This block sits between a host register bus and a pin-side sequencer that drives a physical parallel port. Each host access to the port's register window is turned into one request toward the sequencer, or is answered locally when no pin activity is needed. The host is held with a ready handshake until the sequencer answers or a response timer runs out.

Writes to the data and control registers reach the pins only when the new value differs from the value already stored. Bits 7:6 of every control write are forced to one before the comparison. The block enters an EPP address or EPP data cycle only when the stored control register holds the exact bit pattern for that direction. An illegal EPP write is dropped, and an illegal EPP read returns all ones. A failed or unanswered EPP cycle sets a sticky timeout flag. That flag appears as bit 0 of every status read. Software clears it by writing a status value with bit 0 set.

A second eight-byte window answers locally and never reaches the pins. Writes to it are ignored and reads return 0xFF.

Top module: `ppt_host_front`

## Requirements
- R1: After reset, hb_ready and pr_valid are low, the sticky flag is clear, and hb_ready is never high for two cycles in a row.
- R2: A data write (offset 0) issues a data request with a count of 1 only when its byte differs from the stored data byte (reset value 0xFF). A data read always issues a data read request and returns the response byte.
- R3: A control write (offset 2) stores its byte ORed with 0xC0. It issues a control write request with that value only when the value differs from the stored control byte.
- R4: A control read issues a control read request while no control value is known yet, and stores the answer. Once a value is known from a write or a fetch, a control read returns the stored byte without a request.
- R5: An EPP write (offset 3 address, offset 4 data) issues a request only when (control AND 0x2F) equals 0x04. Bit 5 is direction, bit 3 select, bit 2 init, bit 1 auto-feed and bit 0 strobe. Any other pattern drops the write with no request.
- R6: An EPP read issues a request only when (control AND 0x2F) equals 0x24. Any other pattern returns all ones for the access width with no request: 0xFF for a byte, 0x0000FFFF for a halfword, 0xFFFFFFFF for a word.
- R7: At offset 4, hb_size 0, 1 and 2 (byte, halfword, word) give a count of 1, 2 and 4. The payload and the read data are masked to that width, with byte lane 0 (bits 7:0) as the first byte transferred. Offset 3 always uses a count of 1.
- R8: An EPP request answered with ps_err, or not answered at all, sets the sticky flag. A status read (offset 1) issues a status request and returns the response with bit 0 replaced by the flag. A status write with bit 0 set clears the flag, and one with bit 0 clear leaves it. An error on a request that is not an EPP cycle leaves the flag unchanged.
- R9: If no ps_done arrives within TMO_CYCLES cycles, pr_valid drops, the host is released, and a read returns all ones for its width.
- R10: Accesses with hb_win high, and accesses to offsets 5 to 7, issue no request. Writes to them change no state and reads return 0xFF.
- R11: While a request waits for its response, its kind, count and payload stay stable, and exactly one request is issued per host access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hb_valid | input | 1 | Host access pending; held until hb_ready |
| hb_write | input | 1 | 1 = write, 0 = read |
| hb_win | input | 1 | 1 selects the secondary window |
| hb_ofs | input | 3 | Register offset within the window |
| hb_size | input | 2 | 0 byte, 1 halfword, 2 word (used at offset 4) |
| hb_wdata | input | 32 | Write data, byte lane 0 in bits 7:0 |
| hb_ready | output | 1 | One-cycle completion pulse |
| hb_rdata | output | 32 | Read data, valid while hb_ready is high |
| pr_valid | output | 1 | Pin-side request pending |
| pr_kind | output | 3 | 0 data, 1 status, 2 control, 3 EPP address, 4 EPP data |
| pr_write | output | 1 | Request direction, 1 = write |
| pr_count | output | 3 | Byte count: 1, 2 or 4 |
| pr_wdata | output | 32 | Request payload |
| ps_done | input | 1 | Pin-side response strobe |
| ps_err | input | 1 | Response reports a failed cycle |
| ps_rdata | input | 32 | Response data |

## Verification
The hardest state to reach from the ports is the exact control pattern that opens each EPP direction. The bench drives every one of the 64 values of the low six control bits. After each one it tries an EPP address write and an EPP data read, and it predicts from the pattern alone whether a request appears. The sticky flag and the timeout path are reached by telling the bench's pin model to report an error or to stay silent. The flag is then observed through later status reads.

// File: rtl/ppt_pkg.sv
package ppt_pkg;

   typedef enum logic [2:0] {
      PK_DATA = 3'd0,
      PK_STAT = 3'd1,
      PK_CTRL = 3'd2,
      PK_EADR = 3'd3,
      PK_EDAT = 3'd4
   } pin_kind_t;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_WAIT,
      ST_ACK
   } fe_state_t;

   localparam logic [2:0] OFS_DATA = 3'd0;
   localparam logic [2:0] OFS_STAT = 3'd1;
   localparam logic [2:0] OFS_CTRL = 3'd2;
   localparam logic [2:0] OFS_EADR = 3'd3;
   localparam logic [2:0] OFS_EDAT = 3'd4;

   // direction | select | init | auto-feed | strobe
   localparam logic [7:0] CTL_GATE_MASK = 8'h2F;
   localparam logic [7:0] CTL_EPP_WR    = 8'h04;
   localparam logic [7:0] CTL_EPP_RD    = 8'h24;
   localparam logic [7:0] CTL_FORCED    = 8'hC0;

   function automatic logic [31:0] width_mask(input logic [2:0] n);
      case (n)
         3'd1:    return 32'h0000_00FF;
         3'd2:    return 32'h0000_FFFF;
         default: return 32'hFFFF_FFFF;
      endcase
   endfunction

endpackage

// File: rtl/ppt_access_decode.sv
module ppt_access_decode
   import ppt_pkg::*;
#(
   parameter bit WIDE_EPP = 1'b1
) (
   input  logic        win,
   input  logic        wr,
   input  logic [2:0]  ofs,
   input  logic [1:0]  size,
   input  logic [31:0] wdata,
   input  logic [7:0]  ctrl_q,
   input  logic        ctrl_known,
   input  logic [7:0]  dataw_q,
   output logic        issue,
   output logic [2:0]  kind,
   output logic [2:0]  cnt,
   output logic [31:0] payload,
   output logic [31:0] local_rdata,
   output logic        set_dataw,
   output logic        set_ctrl,
   output logic        clr_tmo,
   output logic [7:0]  ctrl_wval
);

   logic [2:0]  epp_cnt;
   logic [31:0] epp_mask;
   logic [7:0]  gate;

   generate
      if (WIDE_EPP) begin : g_wide
         always_comb begin
            case (size)
               2'd0:    epp_cnt = 3'd1;
               2'd1:    epp_cnt = 3'd2;
               default: epp_cnt = 3'd4;
            endcase
         end
      end else begin : g_narrow
         logic unused_size;
         assign unused_size = ^size;
         assign epp_cnt = 3'd1;
      end
   endgenerate

   assign epp_mask  = width_mask(epp_cnt);
   assign gate      = ctrl_q & CTL_GATE_MASK;
   assign ctrl_wval = wdata[7:0] | CTL_FORCED;

   always_comb begin
      issue       = 1'b0;
      kind        = PK_DATA;
      cnt         = 3'd1;
      payload     = 32'd0;
      local_rdata = 32'h0000_00FF;
      set_dataw   = 1'b0;
      set_ctrl    = 1'b0;
      clr_tmo     = 1'b0;
      if (!win) begin
         case (ofs)
            OFS_DATA: begin
               kind = PK_DATA;
               if (wr) begin
                  if (wdata[7:0] != dataw_q) begin
                     issue     = 1'b1;
                     payload   = {24'd0, wdata[7:0]};
                     set_dataw = 1'b1;
                  end
               end else begin
                  issue = 1'b1;
               end
            end
            OFS_STAT: begin
               kind = PK_STAT;
               if (wr) clr_tmo = wdata[0];
               else    issue   = 1'b1;
            end
            OFS_CTRL: begin
               kind = PK_CTRL;
               if (wr) begin
                  if (ctrl_wval != ctrl_q) begin
                     issue    = 1'b1;
                     payload  = {24'd0, ctrl_wval};
                     set_ctrl = 1'b1;
                  end
               end else if (!ctrl_known) begin
                  issue = 1'b1;
               end else begin
                  local_rdata = {24'd0, ctrl_q};
               end
            end
            OFS_EADR: begin
               kind = PK_EADR;
               if (wr) begin
                  issue   = (gate == CTL_EPP_WR);
                  payload = {24'd0, wdata[7:0]};
               end else begin
                  issue = (gate == CTL_EPP_RD);
               end
            end
            OFS_EDAT: begin
               kind = PK_EDAT;
               cnt  = epp_cnt;
               if (wr) begin
                  issue   = (gate == CTL_EPP_WR);
                  payload = wdata & epp_mask;
               end else begin
                  issue       = (gate == CTL_EPP_RD);
                  local_rdata = epp_mask;
               end
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/ppt_resp_timer.sv
module ppt_resp_timer #(
   parameter int unsigned TMO_CYCLES = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic expired
);

   localparam int unsigned TW = (TMO_CYCLES < 2) ? 1 : $clog2(TMO_CYCLES);

   logic [TW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (!run)   cnt_q <= '0;
      else             cnt_q <= cnt_q + 1'b1;
   end

   assign expired = run && (cnt_q == TW'(TMO_CYCLES - 1));

endmodule

// File: rtl/ppt_host_front.sv
module ppt_host_front
   import ppt_pkg::*;
#(
   parameter int unsigned TMO_CYCLES = 16,
   parameter bit          WIDE_EPP   = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        hb_valid,
   input  logic        hb_write,
   input  logic        hb_win,
   input  logic [2:0]  hb_ofs,
   input  logic [1:0]  hb_size,
   input  logic [31:0] hb_wdata,
   output logic        hb_ready,
   output logic [31:0] hb_rdata,
   output logic        pr_valid,
   output logic [2:0]  pr_kind,
   output logic        pr_write,
   output logic [2:0]  pr_count,
   output logic [31:0] pr_wdata,
   input  logic        ps_done,
   input  logic        ps_err,
   input  logic [31:0] ps_rdata
);

   generate
      if (TMO_CYCLES < 2) begin : g_bad_tmo
         $error("TMO_CYCLES must be at least 2");
      end
   endgenerate

   fe_state_t   state_q;
   logic [7:0]  ctrl_q;
   logic        ctrl_known;
   logic [7:0]  dataw_q;
   logic        tmo_q;

   logic        d_issue, d_set_dataw, d_set_ctrl, d_clr_tmo;
   logic [2:0]  d_kind, d_cnt;
   logic [31:0] d_payload, d_local_rdata;
   logic [7:0]  d_ctrl_wval;
   logic        expired;
   logic        finish;
   logic        failed;
   logic        is_epp;
   logic [31:0] rsp;
   logic [31:0] rsp_fmt;

   ppt_access_decode #(.WIDE_EPP(WIDE_EPP)) u_dec (
      .win         (hb_win),
      .wr          (hb_write),
      .ofs         (hb_ofs),
      .size        (hb_size),
      .wdata       (hb_wdata),
      .ctrl_q      (ctrl_q),
      .ctrl_known  (ctrl_known),
      .dataw_q     (dataw_q),
      .issue       (d_issue),
      .kind        (d_kind),
      .cnt         (d_cnt),
      .payload     (d_payload),
      .local_rdata (d_local_rdata),
      .set_dataw   (d_set_dataw),
      .set_ctrl    (d_set_ctrl),
      .clr_tmo     (d_clr_tmo),
      .ctrl_wval   (d_ctrl_wval)
   );

   ppt_resp_timer #(.TMO_CYCLES(TMO_CYCLES)) u_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (state_q == ST_WAIT),
      .expired (expired)
   );

   assign finish = (state_q == ST_WAIT) && (ps_done || expired);
   assign failed = ps_done ? ps_err : 1'b1;
   assign is_epp = (pr_kind == PK_EADR) || (pr_kind == PK_EDAT);
   assign rsp    = (ps_done ? ps_rdata : 32'hFFFF_FFFF) & width_mask(pr_count);

   always_comb begin
      rsp_fmt = rsp;
      if (pr_kind == PK_STAT) rsp_fmt[0] = tmo_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         hb_ready   <= 1'b0;
         hb_rdata   <= '0;
         pr_valid   <= 1'b0;
         pr_kind    <= PK_DATA;
         pr_write   <= 1'b0;
         pr_count   <= 3'd1;
         pr_wdata   <= '0;
         ctrl_q     <= '0;
         ctrl_known <= 1'b0;
         dataw_q    <= 8'hFF;
         tmo_q      <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (hb_valid) begin
                  if (d_clr_tmo)   tmo_q   <= 1'b0;
                  if (d_set_dataw) dataw_q <= hb_wdata[7:0];
                  if (d_set_ctrl) begin
                     ctrl_q     <= d_ctrl_wval;
                     ctrl_known <= 1'b1;
                  end
                  if (d_issue) begin
                     pr_valid <= 1'b1;
                     pr_kind  <= d_kind;
                     pr_write <= hb_write;
                     pr_count <= d_cnt;
                     pr_wdata <= d_payload;
                     state_q  <= ST_WAIT;
                  end else begin
                     hb_ready <= 1'b1;
                     hb_rdata <= hb_write ? 32'd0 : d_local_rdata;
                     state_q  <= ST_ACK;
                  end
               end
            end
            ST_WAIT: begin
               if (finish) begin
                  pr_valid <= 1'b0;
                  hb_ready <= 1'b1;
                  hb_rdata <= pr_write ? 32'd0 : rsp_fmt;
                  state_q  <= ST_ACK;
                  if (failed && is_epp) tmo_q <= 1'b1;
                  if (!pr_write && pr_kind == PK_CTRL) begin
                     ctrl_q     <= rsp[7:0];
                     ctrl_known <= 1'b1;
                  end
               end
            end
            default: begin
               hb_ready <= 1'b0;
               state_q  <= ST_IDLE;
            end
         endcase
      end
   end

endmodule

// File: rtl/ppt_host_front_chk.sv
module ppt_host_front_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        hb_ready,
   input logic        pr_valid,
   input logic [2:0]  pr_kind,
   input logic        pr_write,
   input logic [2:0]  pr_count,
   input logic [31:0] pr_wdata,
   input logic        ps_done,
   input logic [7:0]  ctrl_q
);

   // R1
   ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hb_ready |=> !hb_ready);

   // R9
   ready_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hb_ready |-> !pr_valid);

   // R11
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pr_valid && !ps_done) |=> ($stable(pr_wdata) && $stable(pr_kind) && $stable(pr_count)));

   // R5
   epp_wr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(pr_valid) && pr_write && (pr_kind == 3'd3 || pr_kind == 3'd4))
         |-> ((ctrl_q & 8'h2F) == 8'h04));

   // R6
   epp_rd_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(pr_valid) && !pr_write && (pr_kind == 3'd3 || pr_kind == 3'd4))
         |-> ((ctrl_q & 8'h2F) == 8'h24));

   // R7
   count_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pr_valid |-> (pr_count == 3'd1 ||
                    (pr_kind == 3'd4 && (pr_count == 3'd2 || pr_count == 3'd4))));

endmodule

bind ppt_host_front ppt_host_front_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .hb_ready (hb_ready),
   .pr_valid (pr_valid),
   .pr_kind  (pr_kind),
   .pr_write (pr_write),
   .pr_count (pr_count),
   .pr_wdata (pr_wdata),
   .ps_done  (ps_done),
   .ctrl_q   (ctrl_q)
);

// File: tb/ppt_host_front_bench.sv
`timescale 1ns/100ps
module ppt_host_front_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        hb_valid = 1'b0, hb_write = 1'b0, hb_win = 1'b0;
   logic [2:0]  hb_ofs = '0;
   logic [1:0]  hb_size = '0;
   logic [31:0] hb_wdata = '0;
   logic        hb_ready;
   logic [31:0] hb_rdata;
   logic        pr_valid, pr_write;
   logic [2:0]  pr_kind, pr_count;
   logic [31:0] pr_wdata;
   logic        ps_done = 1'b0, ps_err = 1'b0;
   logic [31:0] ps_rdata = '0;

   int          nvec = 0, nbad = 0;
   bit          ended = 0;

   // pin model controls and log
   int          rsp_delay = 1;
   bit          rsp_err = 0, rsp_mute = 0;
   logic [31:0] rsp_data = '0;
   int          wcnt = 0;
   logic        pv_q = 1'b0;
   int          req_cnt = 0;
   logic [2:0]  last_kind = '0, last_count = '0;
   logic        last_wr = 1'b0;
   logic [31:0] last_wdata = '0;

   always #2.5 clk = ~clk;

   ppt_host_front u_ppt_host_front (
      .clk(clk), .rst_n(rst_n),
      .hb_valid(hb_valid), .hb_write(hb_write), .hb_win(hb_win), .hb_ofs(hb_ofs),
      .hb_size(hb_size), .hb_wdata(hb_wdata), .hb_ready(hb_ready), .hb_rdata(hb_rdata),
      .pr_valid(pr_valid), .pr_kind(pr_kind), .pr_write(pr_write), .pr_count(pr_count),
      .pr_wdata(pr_wdata), .ps_done(ps_done), .ps_err(ps_err), .ps_rdata(ps_rdata)
   );

   always @(posedge clk) begin
      pv_q    <= pr_valid;
      ps_done <= 1'b0;
      if (pr_valid && !pv_q) begin
         req_cnt    <= req_cnt + 1;
         last_kind  <= pr_kind;
         last_wr    <= pr_write;
         last_count <= pr_count;
         last_wdata <= pr_wdata;
      end
      if (!pr_valid) wcnt <= 0;
      else if (!ps_done && !rsp_mute) begin
         if (wcnt >= rsp_delay) begin
            ps_done  <= 1'b1;
            ps_err   <= rsp_err;
            ps_rdata <= rsp_data;
         end
         wcnt <= wcnt + 1;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nvec++;
      if (act !== exp) begin
         nbad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic hacc(input bit wr, input bit win, input logic [2:0] ofs,
                       input logic [1:0] sz, input logic [31:0] wd,
                       output logic [31:0] rd);
      @(negedge clk);
      hb_valid = 1'b1; hb_write = wr; hb_win = win; hb_ofs = ofs;
      hb_size = sz; hb_wdata = wd;
      do @(negedge clk); while (!hb_ready);
      rd = hb_rdata;
      hb_valid = 1'b0;
   endtask

   function automatic logic [31:0] wmask(input int sz);
      return (sz == 0) ? 32'hFF : (sz == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
   endfunction

   task automatic finish_run();
      if (!ended) begin
         ended = 1;
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
         $finish;
      end
   endtask

   initial begin
      #200000;
      nvec++; nbad++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
   end

   initial begin
      logic [31:0] rd;
      logic [7:0]  dat_m, ctl_m, e;
      int          base;

      repeat (3) @(negedge clk);
      chk("R1 ready at reset", {31'd0, hb_ready}, 32'd0);
      chk("R1 pr_valid at reset", {31'd0, pr_valid}, 32'd0);
      rst_n = 1'b1;

      // status read with clear flag
      rsp_data = 32'h0000_005B;
      hacc(0, 0, 3'd1, 0, 0, rd);
      chk("R1 R8 status flag clear", rd, 32'h5A);
      chk("R8 status kind", {29'd0, last_kind}, 32'd1);

      // control fetch before first write
      rsp_data = 32'h0000_000C; base = req_cnt;
      hacc(0, 0, 3'd2, 0, 0, rd);
      chk("R4 fetch value", rd, 32'h0C);
      chk("R4 fetch request", req_cnt - base, 1);
      chk("R4 fetch kind/dir", {last_kind, last_wr}, {3'd2, 1'b0});
      base = req_cnt;
      hacc(0, 0, 3'd2, 0, 0, rd);
      chk("R4 stored value", rd, 32'h0C);
      chk("R4 no request", req_cnt - base, 0);
      ctl_m = 8'h0C;

      // data writes: change then repeat
      dat_m = 8'hFF;
      for (int k = 0; k < 16; k++) begin
         logic [7:0] v;
         v = 8'(k * 17);
         base = req_cnt;
         hacc(1, 0, 3'd0, 0, {24'hABCDEF, v}, rd);
         chk("R2 data write forwarded", req_cnt - base, (v != dat_m) ? 1 : 0);
         chk("R2 data payload", last_wdata, {24'd0, v});
         dat_m = v;
         base = req_cnt;
         hacc(1, 0, 3'd0, 0, {24'd0, v}, rd);
         chk("R2 repeat suppressed", req_cnt - base, 0);
      end
      rsp_data = 32'h1122_333C;
      hacc(0, 0, 3'd0, 0, 0, rd);
      chk("R2 data read", rd, 32'h3C);

      // exhaustive sweep of low six control bits
      for (int c = 0; c < 64; c++) begin
         e = 8'(c) | 8'hC0;
         base = req_cnt;
         hacc(1, 0, 3'd2, 0, c, rd);
         chk("R3 control write forwarded", req_cnt - base, (e != ctl_m) ? 1 : 0);
         if (e != ctl_m) chk("R3 control payload", last_wdata, {24'd0, e});
         ctl_m = e;
         base = req_cnt;
         hacc(0, 0, 3'd2, 0, 0, rd);
         chk("R3 R4 control readback", rd, {24'd0, e});
         chk("R4 readback no request", req_cnt - base, 0);
         base = req_cnt;
         hacc(1, 0, 3'd3, 0, 32'hA5, rd);
         chk("R5 EPP address write gate", req_cnt - base, ((e & 8'h2F) == 8'h04) ? 1 : 0);
         rsp_data = 32'h0000_0077; base = req_cnt;
         hacc(0, 0, 3'd4, 0, 0, rd);
         chk("R6 EPP read gate", req_cnt - base, ((e & 8'h2F) == 8'h24) ? 1 : 0);
         chk("R6 EPP read data", rd, ((e & 8'h2F) == 8'h24) ? 32'h77 : 32'hFF);
      end

      // widths: write side
      hacc(1, 0, 3'd2, 0, 32'h04, rd);
      for (int s = 0; s < 3; s++) begin
         base = req_cnt;
         hacc(1, 0, 3'd4, 2'(s), 32'h1234_ABCD, rd);
         chk("R7 write issued", req_cnt - base, 1);
         chk("R7 write count", {29'd0, last_count}, (s == 0) ? 1 : (s == 1) ? 2 : 4);
         chk("R7 write payload", last_wdata, 32'h1234_ABCD & wmask(s));
         rsp_data = 32'hDEAD_BEEF;
         hacc(0, 0, 3'd4, 2'(s), 0, rd);
         chk("R6 illegal read width", rd, wmask(s));
      end
      base = req_cnt;
      hacc(1, 0, 3'd3, 2'd2, 32'h1234_5678, rd);
      chk("R7 address count", {29'd0, last_count}, 1);
      // R11: slow responder, one request and stable payload
      rsp_delay = 6;
      base = req_cnt;
      hacc(1, 0, 3'd4, 2'd2, 32'hCAFE_F00D, rd);
      chk("R11 single request", req_cnt - base, 1);
      chk("R11 payload", last_wdata, 32'hCAFE_F00D);
      rsp_delay = 1;
      // widths: read side
      hacc(1, 0, 3'd2, 0, 32'h24, rd);
      for (int s = 0; s < 3; s++) begin
         rsp_data = 32'hDEAD_BEEF;
         hacc(0, 0, 3'd4, 2'(s), 0, rd);
         chk("R7 read data", rd, 32'hDEAD_BEEF & wmask(s));
         chk("R7 read count", {29'd0, last_count}, (s == 0) ? 1 : (s == 1) ? 2 : 4);
      end

      // sticky flag
      rsp_data = 32'h0;
      rsp_err = 1;
      hacc(1, 0, 3'd0, 0, 32'h5A, rd);
      hacc(0, 0, 3'd1, 0, 0, rd);
      chk("R8 non-EPP error ignored", rd, 32'h00);
      rsp_err = 1;
      hacc(0, 0, 3'd3, 0, 0, rd);
      rsp_err = 0;
      hacc(0, 0, 3'd1, 0, 0, rd);
      chk("R8 flag set by error", rd, 32'h01);
      hacc(1, 0, 3'd1, 0, 32'hFE, rd);
      hacc(0, 0, 3'd1, 0, 0, rd);
      chk("R8 write bit0=0 keeps flag", rd, 32'h01);
      hacc(1, 0, 3'd1, 0, 32'h01, rd);
      hacc(0, 0, 3'd1, 0, 0, rd);
      chk("R8 write bit0=1 clears", rd, 32'h00);

      // timeout
      rsp_mute = 1;
      hacc(0, 0, 3'd4, 2'd2, 0, rd);
      chk("R9 timeout read ones", rd, 32'hFFFF_FFFF);
      chk("R9 request dropped", {31'd0, pr_valid}, 32'd0);
      rsp_mute = 0;
      hacc(0, 0, 3'd1, 0, 0, rd);
      chk("R9 R8 flag after timeout", rd, 32'h01);

      // secondary window and unused offsets
      for (int o = 0; o < 8; o++) begin
         base = req_cnt;
         hacc(1, 1, 3'(o), 0, 32'h00, rd);
         hacc(0, 1, 3'(o), 0, 0, rd);
         chk("R10 window read", rd, 32'hFF);
         chk("R10 window no request", req_cnt - base, 0);
      end
      for (int o = 5; o < 8; o++) begin
         base = req_cnt;
         hacc(1, 0, 3'(o), 0, 32'h00, rd);
         hacc(0, 0, 3'(o), 0, 0, rd);
         chk("R10 spare offset read", rd, 32'hFF);
         chk("R10 spare no request", req_cnt - base, 0);
      end
      hacc(0, 0, 3'd2, 0, 0, rd);
      chk("R10 control untouched", rd, 32'hE4);

      finish_run();
   end

endmodule